// File: doc/BRIEF.md
# MDIO Management Master

This block serialises management frames for external PHY devices over a two-wire link. One output is the management clock. The data line is bidirectional and is presented as a separate output value, output enable and input. A host loads one 32-bit command word. The block then clocks the frame out, captures the reply when the frame is a read, and sets a sticky completion flag that the host polls and clears by writing one.

The management clock comes from the block clock through a programmable divider. The clock only toggles while a frame is in flight; between frames it rests low and the data line is released. A configuration bit can drop the 32-bit all-ones preamble, so that frames to PHYs that accept this are shorter.

The command word keeps the frame's own bit order, MSB first. Bits [31:30] hold the start code (normally 01) and [29:28] the opcode: 01 is a write and 10 is a read. Bits [27:23] hold the PHY address and [22:18] the register address. Bits [17:16] hold the turnaround and [15:0] the write data.

Top module: `mdio_master`

## Requirements
- R1: With divider value D > 0, each high phase and each low phase of `mdc` within a frame lasts D block-clock cycles. With D = 0, `cmd_wr` starts no frame: `mdc` stays low and `done` stays 0.
- R2: With `cfg_nopre` = 0, a frame has 64 bit times, and the first 32 are logic 1. With `cfg_nopre` = 1, a frame has 32 bit times and begins with command bit 31.
- R3: After any preamble, the driven bit times carry command word bits 31 down to 0 in that order.
- R4: For any opcode other than 10, `mdio_oe` is 1 for every bit time of the frame, including both turnaround bits, which are taken from the command word.
- R5: For opcode 10, `mdio_oe` is 0 from the first turnaround bit (frame bit 14 after any preamble) to the end of the frame. The 16 bits `mdio_i` presents after the turnaround are sampled on the rising edges of `mdc`, MSB first, and placed in `rd_data` when the frame ends.
- R6: Outside a frame, `mdio_oe` = 0 and `mdc` = 0; this is also the state after reset, together with `done` = 0 and `rd_data` = 0.
- R7: `done` is set in the same cycle as the final falling edge of `mdc`. It stays set until a cycle with `done_clr` = 1 clears it.
- R8: A `cmd_wr` that arrives while a frame is in progress is ignored. The running frame is neither changed nor restarted.
- R9: The driven data value changes only in the cycle in which `mdc` falls.
- R10: A `cfg_wr` that arrives while a frame is in progress has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load divider and preamble control |
| cfg_div | input | DIV_W | Half-period of `mdc` in block-clock cycles; 0 disables |
| cfg_nopre | input | 1 | 1 drops the 32-bit preamble |
| cmd_wr | input | 1 | Load command word and start a frame |
| cmd_word | input | 32 | Command word (start, opcode, PHY, register, turnaround, data) |
| done_clr | input | 1 | Write-one clear of `done` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value seen at the pin |
| rd_data | output | 16 | Data captured by the last read |
| done | output | 1 | Sticky completion flag |

## Verification
The checker watches some rules on every cycle. The line is idle and the clock low outside a frame. Driven data moves only when `mdc` falls. `done` rises only together with a falling clock. A mid-frame command leaves the latched word untouched. A zero divider keeps the clock low. Other behaviour needs the bench's PHY model and its sweep over divider, preamble mode and opcode. That covers the exact phase lengths, the bit-by-bit frame content, where the line is released in a read, and the captured read value. It also shows that a command or configuration write arriving mid-frame leaves the bit stream unchanged.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_nopre,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_word,
  input  logic             done_clr,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i,
  output logic [15:0]      rd_data,
  output logic             done
);

  localparam logic [5:0] LAST_IDX = 6'd63;
  localparam logic [5:0] TA_IDX   = 6'd46;
  localparam logic [5:0] DATA_IDX = 6'd48;

  logic [DIV_W-1:0] div_q, cnt;
  logic             nopre_q, busy, mdc_q;
  logic [5:0]       idx;
  logic [31:0]      cmd_q;
  logic [15:0]      rd_sh;

  wire is_rd = (cmd_q[29:28] == 2'b10);
  wire tick  = busy && (cnt == div_q - DIV_W'(1));

  assign mdc     = mdc_q;
  assign mdio_oe = busy && !(is_rd && idx >= TA_IDX);
  assign mdio_o  = busy && (idx[5] ? cmd_q[~idx[4:0]] : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      nopre_q <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      mdc_q   <= 1'b0;
      idx     <= '0;
      cmd_q   <= '0;
      rd_sh   <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      if (done_clr) done <= 1'b0;
      if (!busy) begin
        if (cfg_wr) begin
          div_q   <= cfg_div;
          nopre_q <= cfg_nopre;
        end
        if (cmd_wr && div_q != '0) begin
          busy  <= 1'b1;
          cnt   <= '0;
          mdc_q <= 1'b0;
          idx   <= nopre_q ? 6'd32 : 6'd0;
          cmd_q <= cmd_word;
        end
      end else if (tick) begin
        cnt   <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          if (is_rd && idx >= DATA_IDX) rd_sh <= {rd_sh[14:0], mdio_i};
        end else if (idx == LAST_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (is_rd) rd_data <= rd_sh;
        end else begin
          idx <= idx + 6'd1;
        end
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        done,
  input logic        cmd_wr,
  input logic        busy,
  input logic [31:0] cmd_q,
  input logic        div_zero
);

  p_div_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> !mdc);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(mdc));

  p_cmd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q));

  p_drive_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .done     (done),
  .cmd_wr   (cmd_wr),
  .busy     (busy),
  .cmd_q    (cmd_q),
  .div_zero (~|div_q)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int CLK_P = 10;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic             cfg_nopre = 1'b0;
  logic             cmd_wr = 1'b0;
  logic [31:0]      cmd_word = '0;
  logic             done_clr = 1'b0;
  logic             mdc, mdio_o, mdio_oe, done;
  logic             mdio_i = 1'b1;
  logic [15:0]      rd_data;

  int checks = 0;
  int errors = 0;

  mdio_master #(.DIV_W(DIV_W)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
    .cfg_nopre(cfg_nopre), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .done_clr(done_clr), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i), .rd_data(rd_data), .done(done)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [1:0] ta,
                                     input logic [15:0] d);
    return {2'b01, op, phy, rg, ta, d};
  endfunction

  task automatic run_frame(input int dv, input bit np, input logic [31:0] w,
                           input logic [15:0] rv, input bit inject);
    int base, n, nb, p, cyc, run;
    int bad_o, bad_oe, bad_ph, bad_edge;
    bit rd, first, prev_mdc, prev_o, prev_oe, exp_b, exp_oe;
    @(negedge clk); cfg_wr = 1'b1; cfg_div = DIV_W'(dv); cfg_nopre = np;
    @(negedge clk); cfg_wr = 1'b0; cmd_wr = 1'b1; cmd_word = w;
    @(negedge clk); cmd_wr = 1'b0;
    base = np ? 0 : 32;
    n = base + 32;
    rd = (w[29:28] == 2'b10);
    nb = 0; cyc = 0; run = 0; first = 1'b1;
    bad_o = 0; bad_oe = 0; bad_ph = 0; bad_edge = 0;
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    while (!done && cyc < 5000) begin
      if (!mdc) begin
        p = nb - base;
        if (rd && p == 15) mdio_i = 1'b0;
        else if (rd && p >= 16 && p < 32) mdio_i = rv[31-p];
        else mdio_i = 1'b1;
      end
      @(negedge clk);
      cyc++;
      if (mdc && !prev_mdc) begin
        p = nb - base;
        exp_b  = (p < 0) ? 1'b1 : w[31-p];
        exp_oe = !(rd && p >= 14);
        if (mdio_oe != exp_oe) bad_oe++;
        if (exp_oe && mdio_o != exp_b) bad_o++;
        nb++;
      end
      if (mdc != prev_mdc) begin
        if (!first && run != dv) bad_ph++;
        first = 1'b0;
        run = 1;
      end else run++;
      if (mdio_oe && prev_oe && mdio_o != prev_o && !(prev_mdc && !mdc)) bad_edge++;
      if (inject && cyc == 40) begin
        cmd_wr = 1'b1; cmd_word = ~w; cfg_wr = 1'b1;
        cfg_div = DIV_W'(dv + 1); cfg_nopre = ~np;
      end else if (inject && cyc == 41) begin
        cmd_wr = 1'b0; cfg_wr = 1'b0;
      end
      prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end
    chk(nb == n, "R2 bit count", nb, n);
    chk(bad_o == 0, "R3 frame bits", bad_o, 0);
    chk(bad_oe == 0, rd ? "R5 read release" : "R4 write drive", bad_oe, 0);
    chk(bad_ph == 0, "R1 phase length", bad_ph, 0);
    chk(bad_edge == 0, "R9 change on fall", bad_edge, 0);
    chk(done == 1'b1, "R7 done set", done, 1);
    if (rd) chk(rd_data == rv, "R5 read data", rd_data, rv);
    if (inject) chk(nb == n && bad_o == 0 && bad_ph == 0, "R8 R10 mid-frame writes ignored", bad_o + bad_ph, 0);
    chk(!mdio_oe && !mdc, "R6 idle after frame", {mdio_oe, mdc}, 0);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    chk(done == 1'b0, "R7 clear", done, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit seen_mdc, seen_oe;
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe && !done && rd_data == 0, "R6 reset state", {mdc, mdio_oe, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_wr = 1'b1; cfg_div = '0; cfg_nopre = 1'b0;
    @(negedge clk); cfg_wr = 1'b0; cmd_wr = 1'b1; cmd_word = mk(2'b01, 5'd3, 5'd4, 2'b10, 16'hFFFF);
    @(negedge clk); cmd_wr = 1'b0;
    seen_mdc = 1'b0; seen_oe = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mdc) seen_mdc = 1'b1;
      if (mdio_oe) seen_oe = 1'b1;
    end
    chk(!seen_mdc && !seen_oe && !done, "R1 zero divider", {seen_mdc, seen_oe, done}, 0);

    for (int dv = 1; dv <= 3; dv++)
      for (int np = 0; np <= 1; np++)
        for (int opi = 0; opi <= 1; opi++) begin
          logic [1:0]  op;
          logic [15:0] wd, rv;
          op = opi ? 2'b10 : 2'b01;
          wd = 16'hA5C3 ^ 16'(dv * 16'h1111) ^ 16'(np * 16'h0F0F);
          rv = 16'(16'h1234 * dv) ^ 16'(np * 16'h8001) ^ 16'(opi * 16'h4C00);
          run_frame(dv, np[0],
                    mk(op, 5'(dv * 7 + np * 3), 5'(31 - dv * 5 - opi), opi ? 2'b11 : 2'b10, wd),
                    rv, dv == 2);
        end

    run_frame(1, 1'b0, mk(2'b11, 5'd31, 5'd0, 2'b01, 16'h8001), 16'h0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule